// File: doc/BRIEF.md
# Bus Master Security Filter

This block guards the path from one bus-mastering device (a DMA engine, for example) into the system interconnect. Every request the master issues is checked against two things: whether the master is currently classed as non-secure, and whether the target address is attributed secure by an external, purely combinational attribution lookup. A non-secure master touching a secure address is rejected. Every other request travels downstream unchanged, and its response comes back unchanged.

The policy is set only by pins, with no software-visible registers. One pin classes the master as non-secure, one selects the style of rejection, and one strobe clears the interrupt. A rejected request is answered by the filter itself. It either returns a bus error, or it reads as zero with the write discarded. The rejection also sets a sticky interrupt that stays up until the clear strobe is applied. Only one transaction is in flight at a time.

Top module: `bus_master_sec_filter`

## Requirements
- R1: After reset `irq` is 0, `up_req_ready` is 1, and both `dn_req_valid` and `up_rsp_valid` are 0.
- R2: The lookup output `attr_addr` always equals `up_addr`. A request accepted while `cfg_master_ns`=1 and `attr_secure`=1 is rejected. Every other combination passes, including a secure master (`cfg_master_ns`=0) to any address and any master to an address with `attr_secure`=0.
- R3: A passed request appears on `dn_req_valid` in the cycle after acceptance, with `dn_addr`, `dn_write` and `dn_wdata` equal to the accepted values. It is held there until `dn_req_ready` is 1.
- R4: While a passed request awaits its response, `up_rsp_valid`, `up_rsp_rdata` and `up_rsp_err` mirror `dn_rsp_valid`, `dn_rsp_rdata` and `dn_rsp_err` in the same cycle. At any other time `dn_rsp_valid` has no effect on `up_rsp_valid`.
- R5: A rejected request, read or write, never raises `dn_req_valid`.
- R6: A rejected request is answered with `up_rsp_valid`=1 for exactly one cycle, in the cycle after acceptance, with `up_rsp_rdata`=0. `up_rsp_err` in that cycle equals the value `cfg_err_resp` had in the acceptance cycle: 1 means a bus error, 0 means read-as-zero with the write dropped.
- R7: `irq` becomes 1 in the cycle after a rejection is accepted and stays 1 until cleared.
- R8: `irq_clr`=1 in a cycle makes `irq` 0 in the next cycle. This holds even if a rejection is accepted in that same cycle.
- R9: `up_req_ready` is 0 from the cycle after acceptance until the response cycle has passed. It is 1 again in the cycle after the response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_master_ns | input | 1 | 1: master treated as non-secure |
| cfg_err_resp | input | 1 | 1: rejection gives bus error; 0: read-as-zero, write dropped |
| irq_clr | input | 1 | Clears the rejection interrupt |
| attr_addr | output | AW | Address presented to the attribution lookup |
| attr_secure | input | 1 | Lookup result: 1 means the address is secure |
| up_req_valid | input | 1 | Master request valid |
| up_req_ready | output | 1 | Filter can accept a request |
| up_addr | input | AW | Request address |
| up_write | input | 1 | 1: write, 0: read |
| up_wdata | input | DW | Write data |
| up_rsp_valid | output | 1 | Response to master valid |
| up_rsp_rdata | output | DW | Response read data |
| up_rsp_err | output | 1 | Response error flag |
| dn_req_valid | output | 1 | Forwarded request valid |
| dn_req_ready | input | 1 | Interconnect accepts forwarded request |
| dn_addr | output | AW | Forwarded address |
| dn_write | output | 1 | Forwarded write flag |
| dn_wdata | output | DW | Forwarded write data |
| dn_rsp_valid | input | 1 | Interconnect response valid |
| dn_rsp_rdata | input | DW | Interconnect read data |
| dn_rsp_err | input | 1 | Interconnect error flag |
| irq | output | 1 | Sticky rejection interrupt |

## Verification
A rejection's local response and the interrupt it raises are both due one cycle after the acceptance edge, and a forwarded request shows up downstream in that same cycle. A downstream response is passed back within its own cycle, and ready returns one cycle after the response. The bench drives every input on the falling edge and samples one time unit later, so each check lands in exactly the cycle its requirement names. It also flips `cfg_err_resp` right after acceptance, which confirms that the response style was captured at acceptance. Random transactions are compared with a bench model of the pass rule and the interrupt state. Directed cases cover clear-versus-reject collisions and stray downstream responses.

// File: rtl/sec_filter_pkg.sv
package sec_filter_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FWD   = 2'd1,
    ST_WAIT  = 2'd2,
    ST_LOCAL = 2'd3
  } txn_state_t;

  // Pass rule: only a non-secure master aimed at a secure address is refused.
  function automatic logic req_blocked(input logic master_ns, input logic addr_secure);
    return master_ns & addr_secure;
  endfunction

  // Sticky interrupt update; the clear strobe dominates.
  function automatic logic irq_next(input logic cur, input logic reject, input logic clr);
    if (clr) return 1'b0;
    return cur | reject;
  endfunction

endpackage

// File: rtl/sf_policy.sv
module sf_policy (
  input  logic master_ns,
  input  logic addr_secure,
  output logic blocked
);
  import sec_filter_pkg::*;

  always_comb blocked = req_blocked(master_ns, addr_secure);

  // R2
  always_comb begin
    pass_secure_master_chk: assert (master_ns || !blocked);
  end
endmodule

// File: rtl/sf_irq_status.sv
module sf_irq_status (
  input  logic clk,
  input  logic rst_n,
  input  logic reject,
  input  logic clr,
  output logic irq
);
  import sec_filter_pkg::*;

  logic stat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= 1'b0;
    else        stat_q <= irq_next(stat_q, reject, clr);
  end

  assign irq = stat_q;

  // R7
  irq_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reject && !clr |=> irq);
  // R8
  irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !irq);
  // R7
  irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq && !clr |=> irq);
endmodule

// File: rtl/sf_txn_ctrl.sv
module sf_txn_ctrl #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          blocked,
  input  logic          cfg_err_resp,
  input  logic          up_req_valid,
  output logic          up_req_ready,
  input  logic [AW-1:0] up_addr,
  input  logic          up_write,
  input  logic [DW-1:0] up_wdata,
  output logic          up_rsp_valid,
  output logic [DW-1:0] up_rsp_rdata,
  output logic          up_rsp_err,
  output logic          dn_req_valid,
  input  logic          dn_req_ready,
  output logic [AW-1:0] dn_addr,
  output logic          dn_write,
  output logic [DW-1:0] dn_wdata,
  input  logic          dn_rsp_valid,
  input  logic [DW-1:0] dn_rsp_rdata,
  input  logic          dn_rsp_err,
  output logic          accept_evt,
  output logic          reject_evt
);
  import sec_filter_pkg::*;

  localparam logic [DW-1:0] ZERO_DATA = '0;

  txn_state_t   state_q, state_d;
  logic [AW-1:0] addr_q;
  logic          write_q;
  logic [DW-1:0] wdata_q;
  logic          err_q;

  assign up_req_ready = (state_q == ST_IDLE);
  assign accept_evt   = up_req_valid && up_req_ready;
  assign reject_evt   = accept_evt && blocked;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (accept_evt) state_d = blocked ? ST_LOCAL : ST_FWD;
      ST_FWD:   if (dn_req_ready) state_d = ST_WAIT;
      ST_WAIT:  if (dn_rsp_valid) state_d = ST_IDLE;
      ST_LOCAL: state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      write_q <= 1'b0;
      wdata_q <= '0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept_evt) begin
        addr_q  <= up_addr;
        write_q <= up_write;
        wdata_q <= up_wdata;
        err_q   <= cfg_err_resp;
      end
    end
  end

  assign dn_req_valid = (state_q == ST_FWD);
  assign dn_addr      = addr_q;
  assign dn_write     = write_q;
  assign dn_wdata     = wdata_q;

  always_comb begin
    up_rsp_valid = 1'b0;
    up_rsp_rdata = ZERO_DATA;
    up_rsp_err   = 1'b0;
    if (state_q == ST_WAIT) begin
      up_rsp_valid = dn_rsp_valid;
      up_rsp_rdata = dn_rsp_rdata;
      up_rsp_err   = dn_rsp_err;
    end else if (state_q == ST_LOCAL) begin
      up_rsp_valid = 1'b1;
      up_rsp_err   = err_q;
    end
  end

  // R5
  reject_no_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reject_evt |=> !dn_req_valid && up_rsp_valid);
  // R6
  reject_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reject_evt |=> (up_rsp_rdata == ZERO_DATA) && (up_rsp_err == $past(cfg_err_resp)));
  // R6
  reject_one_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reject_evt |=> ##1 !up_rsp_valid);
  // R9
  single_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept_evt |=> !up_req_ready);
  // R3
  fwd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dn_req_valid && !dn_req_ready |=> dn_req_valid && $stable(dn_addr) && $stable(dn_wdata));
  // R3
  fwd_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept_evt && !blocked |=> dn_req_valid && (dn_addr == $past(up_addr)));
  // R9
  ready_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
    up_rsp_valid |=> up_req_ready);
endmodule

// File: rtl/bus_master_sec_filter.sv
module bus_master_sec_filter #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_master_ns,
  input  logic          cfg_err_resp,
  input  logic          irq_clr,
  output logic [AW-1:0] attr_addr,
  input  logic          attr_secure,
  input  logic          up_req_valid,
  output logic          up_req_ready,
  input  logic [AW-1:0] up_addr,
  input  logic          up_write,
  input  logic [DW-1:0] up_wdata,
  output logic          up_rsp_valid,
  output logic [DW-1:0] up_rsp_rdata,
  output logic          up_rsp_err,
  output logic          dn_req_valid,
  input  logic          dn_req_ready,
  output logic [AW-1:0] dn_addr,
  output logic          dn_write,
  output logic [DW-1:0] dn_wdata,
  input  logic          dn_rsp_valid,
  input  logic [DW-1:0] dn_rsp_rdata,
  input  logic          dn_rsp_err,
  output logic          irq
);

  logic blocked;
  logic accept_evt;
  logic reject_evt;

  assign attr_addr = up_addr;

  sf_policy u_policy (
    .master_ns   (cfg_master_ns),
    .addr_secure (attr_secure),
    .blocked     (blocked)
  );

  sf_txn_ctrl #(.AW(AW), .DW(DW)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .blocked      (blocked),
    .cfg_err_resp (cfg_err_resp),
    .up_req_valid (up_req_valid),
    .up_req_ready (up_req_ready),
    .up_addr      (up_addr),
    .up_write     (up_write),
    .up_wdata     (up_wdata),
    .up_rsp_valid (up_rsp_valid),
    .up_rsp_rdata (up_rsp_rdata),
    .up_rsp_err   (up_rsp_err),
    .dn_req_valid (dn_req_valid),
    .dn_req_ready (dn_req_ready),
    .dn_addr      (dn_addr),
    .dn_write     (dn_write),
    .dn_wdata     (dn_wdata),
    .dn_rsp_valid (dn_rsp_valid),
    .dn_rsp_rdata (dn_rsp_rdata),
    .dn_rsp_err   (dn_rsp_err),
    .accept_evt   (accept_evt),
    .reject_evt   (reject_evt)
  );

  sf_irq_status u_irq (
    .clk    (clk),
    .rst_n  (rst_n),
    .reject (reject_evt),
    .clr    (irq_clr),
    .irq    (irq)
  );

  // R2
  secure_master_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept_evt && !cfg_master_ns |=> !irq || $past(irq));
endmodule

// File: tb/tb_bus_master_sec_filter.sv
module tb_bus_master_sec_filter;
  localparam int AW = 32;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_master_ns = 1'b0, cfg_err_resp = 1'b0, irq_clr = 1'b0;
  logic [AW-1:0] attr_addr;
  logic          attr_secure;
  logic          up_req_valid = 1'b0, up_write = 1'b0;
  logic [AW-1:0] up_addr = '0;
  logic [DW-1:0] up_wdata = '0;
  logic          up_req_ready, up_rsp_valid, up_rsp_err;
  logic [DW-1:0] up_rsp_rdata;
  logic          dn_req_valid, dn_write;
  logic          dn_req_ready = 1'b0, dn_rsp_valid = 1'b0, dn_rsp_err = 1'b0;
  logic [AW-1:0] dn_addr;
  logic [DW-1:0] dn_wdata;
  logic [DW-1:0] dn_rsp_rdata = '0;
  logic          irq;

  int n_checks = 0;
  int n_fail   = 0;
  logic exp_irq = 1'b0;
  bit done = 0;

  always #10 clk = ~clk;

  // Bench attribution map: bit 28 of the address marks a secure region.
  function automatic logic sec_of(input logic [AW-1:0] a);
    return a[28];
  endfunction
  function automatic logic exp_block(input logic ns, input logic [AW-1:0] a);
    return (ns == 1'b1) && (sec_of(a) == 1'b1);
  endfunction
  function automatic logic [DW-1:0] slave_data(input logic [AW-1:0] a, input logic [DW-1:0] d);
    return {a[15:0], a[31:16]} ^ d ^ 32'h5A3C_0F96;
  endfunction

  assign attr_secure = sec_of(attr_addr);

  bus_master_sec_filter #(.AW(AW), .DW(DW)) dut (.*);

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic run_txn(input logic [AW-1:0] a, input logic w, input logic [DW-1:0] d,
                         input logic ns, input logic es, input logic clr,
                         input int dly_rdy, input int dly_rsp);
    logic blk;
    logic [DW-1:0] rd;
    logic rerr;
    blk = exp_block(ns, a);
    @(negedge clk);
    up_req_valid = 1'b1; up_addr = a; up_write = w; up_wdata = d;
    cfg_master_ns = ns; cfg_err_resp = es; irq_clr = clr;
    #1;
    chk(up_req_ready === 1'b1, "R9 ready idle", up_req_ready, 1);
    chk(attr_addr === a, "R2 lookup addr", attr_addr, a);
    @(posedge clk);
    exp_irq = clr ? 1'b0 : (exp_irq | blk);
    @(negedge clk);
    up_req_valid = 1'b0; irq_clr = 1'b0; cfg_err_resp = ~es;
    #1;
    chk(irq === exp_irq, clr ? "R8 irq clear" : "R7 irq", irq, exp_irq);
    chk(up_req_ready === 1'b0, "R9 busy", up_req_ready, 0);
    if (blk) begin
      chk(dn_req_valid === 1'b0, "R5 no forward", dn_req_valid, 0);
      chk(up_rsp_valid === 1'b1, "R6 local rsp", up_rsp_valid, 1);
      chk(up_rsp_rdata === '0, "R6 zero data", up_rsp_rdata, 0);
      chk(up_rsp_err === es, "R6 err style", up_rsp_err, es);
      @(negedge clk); #1;
      chk(up_rsp_valid === 1'b0, "R6 single rsp", up_rsp_valid, 0);
      chk(dn_req_valid === 1'b0, "R5 no forward late", dn_req_valid, 0);
      chk(up_req_ready === 1'b1, "R9 ready back", up_req_ready, 1);
    end else begin
      chk(up_rsp_valid === 1'b0, "R2 no local rsp", up_rsp_valid, 0);
      chk(dn_req_valid === 1'b1, "R3 forward", dn_req_valid, 1);
      chk(dn_addr === a, "R3 addr", dn_addr, a);
      chk(dn_write === w, "R3 write", dn_write, w);
      chk(dn_wdata === d, "R3 wdata", dn_wdata, d);
      repeat (dly_rdy) @(negedge clk);
      #1;
      chk(dn_req_valid === 1'b1 && dn_addr === a, "R3 hold", dn_req_valid, 1);
      dn_req_ready = 1'b1;
      @(negedge clk);
      dn_req_ready = 1'b0;
      #1;
      chk(dn_req_valid === 1'b0, "R3 drop after ready", dn_req_valid, 0);
      chk(up_req_ready === 1'b0, "R9 wait", up_req_ready, 0);
      repeat (dly_rsp) @(negedge clk);
      rd = slave_data(a, d); rerr = a[2];
      dn_rsp_valid = 1'b1; dn_rsp_rdata = rd; dn_rsp_err = rerr;
      #1;
      chk(up_rsp_valid === 1'b1, "R4 rsp valid", up_rsp_valid, 1);
      chk(up_rsp_rdata === rd, "R4 rsp data", up_rsp_rdata, rd);
      chk(up_rsp_err === rerr, "R4 rsp err", up_rsp_err, rerr);
      @(negedge clk);
      dn_rsp_valid = 1'b0;
      #1;
      chk(up_rsp_valid === 1'b0, "R4 rsp done", up_rsp_valid, 0);
      chk(up_req_ready === 1'b1, "R9 ready back", up_req_ready, 1);
    end
    chk(irq === exp_irq, "R7 irq held", irq, exp_irq);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] seed;
    seed = 32'd20240611;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    #1;
    // R1 reset state
    chk(irq === 1'b0, "R1 irq", irq, 0);
    chk(up_req_ready === 1'b1, "R1 ready", up_req_ready, 1);
    chk(dn_req_valid === 1'b0, "R1 dn valid", dn_req_valid, 0);
    chk(up_rsp_valid === 1'b0, "R1 rsp valid", up_rsp_valid, 0);
    @(negedge clk); rst_n = 1'b1;

    // R4: stray downstream response while idle has no effect
    @(negedge clk); dn_rsp_valid = 1'b1; dn_rsp_rdata = 32'hDEAD_BEEF; #1;
    chk(up_rsp_valid === 1'b0, "R4 stray rsp ignored", up_rsp_valid, 0);
    @(negedge clk); dn_rsp_valid = 1'b0; #1;
    chk(up_req_ready === 1'b1, "R4 stray rsp no state", up_req_ready, 1);

    // R2 directed: secure master to secure address passes
    run_txn(32'h1000_0040, 1'b0, 32'h0, 1'b0, 1'b1, 1'b0, 0, 0);
    // R2 directed: non-secure master to non-secure address passes
    run_txn(32'h2000_0004, 1'b1, 32'h1234_5678, 1'b1, 1'b1, 1'b0, 2, 1);
    // R6 read-as-zero, write dropped
    run_txn(32'h1000_0100, 1'b1, 32'hFFFF_FFFF, 1'b1, 1'b0, 1'b0, 0, 0);
    // R6 bus error on read
    run_txn(32'h1000_0200, 1'b0, 32'h0, 1'b1, 1'b1, 1'b0, 0, 0);
    // R8 pulse clear alone
    @(negedge clk); irq_clr = 1'b1;
    @(posedge clk); exp_irq = 1'b0;
    @(negedge clk); irq_clr = 1'b0; #1;
    chk(irq === 1'b0, "R8 clear alone", irq, 0);
    // R8 clear collides with a rejection
    run_txn(32'h1000_0300, 1'b0, 32'h0, 1'b1, 1'b1, 1'b1, 0, 0);

    for (int i = 0; i < 300; i++) begin
      logic [31:0] a;
      a = $urandom;
      run_txn(a, 1'($urandom), $urandom, 1'($urandom), 1'($urandom),
              ($urandom % 8) == 0, int'($urandom % 4), int'($urandom % 4));
    end

    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule